// File: doc/BRIEF.md
# Low-Power State Exit Sequencer

This block follows the power state of a single memory device and moves it into and out of two low-power states. The light state is a nap. The deeper state is a power-down. A request on the row command side puts the device into nap or power-down. At that moment the block records three things: whether the device should later return to standby or to attention, whether it entered the active variant of the state, and which of the two states it entered.

The device leaves the low-power state when it receives an exit frame on a single serial command line. The line is sampled once every `DIV` system clocks, and the block makes this slow serial rate from the system clock with a clock enable. A frame is addressed to one device by a 6-bit identifier, unless broadcast mode is configured. During the wake period the block raises flags that forbid row packets, and forbid column packets as well when the device entered the active variant. It also enforces two lockouts: one that follows entry and one that follows a completed exit.

The serial line is passed on to a downstream device through a registered output. A one-hot state output and a one-cycle arrival pulse let a system controller or a testbench see each wake latency.

Top module: `lpx_exit_seq`

## Requirements
- R1: After reset the state output is standby (one-hot code 5'b00010). The arrival pulse, both blocking flags and the protocol-error flag are low. The state output always has exactly one bit set: bit 0 attention, bit 1 standby, bit 2 nap, bit 3 power-down, bit 4 exiting.
- R2: An entry request is accepted only in attention or standby. `ent_pdn`=0 selects nap and `ent_pdn`=1 selects power-down, and the new state is visible in the next cycle. A request made in nap, power-down or exiting leaves the state unchanged.
- R3: An exit frame is sampled on serial ticks, which occur once every `DIV` clocks. It is a 0, then a 1, then the exit code (0 = nap exit, 1 = power-down exit), then 6 identifier bits with the most significant bit first, unless broadcast is configured. When the frame is accepted, the state shows exiting from the cycle after the last frame bit.
- R4: In addressed mode, a frame whose identifier differs from `cfg_dev_id` leaves the state unchanged and raises no error. In broadcast mode no identifier bits are sent or checked.
- R5: The exiting state lasts exactly N×`DIV` clocks. For a nap, N is `cfg_nap_wake`. For a power-down, N is 256×`cfg_pdn_wake`. A programmed zero counts as N=1.
- R6: When the wake period ends, the state becomes standby if the relax input was high at entry and attention otherwise. `arrive` is high for exactly the first cycle in that state.
- R7: `row_blk` is high for every cycle of the exiting state. `col_blk` is high for those same cycles only when `ent_avar` was high at entry, and it is low otherwise.
- R8: After an entry, a frame that completes within 5 clocks plus (2+N) serial ticks is discarded without error. A frame that completes later is accepted.
- R9: After an arrival, entry requests are ignored during the first L cycles in the new state and accepted from cycle L+1 onward. L is 8 when the slow bit of the state just left (`cfg_nap_slow` or `cfg_pdn_slow`) is 0, and 23 when it is 1.
- R10: A frame that reaches this device while it is not in nap or power-down, or whose exit code does not match the current state, sets `proto_err`. The flag stays set until reset, and the state does not change.
- R11: At each serial tick, `sio_out` takes the value of `scmd` sampled at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_req | input | 1 | Low-power entry request from the row channel |
| ent_pdn | input | 1 | Entry target: 0 nap, 1 power-down |
| ent_relax | input | 1 | Return to standby (1) or attention (0) after exit |
| ent_avar | input | 1 | Entry into the active variant; column packets are blocked during the exit |
| scmd | input | 1 | Serial command line |
| cfg_bcast | input | 1 | Broadcast exit, no identifier field |
| cfg_dev_id | input | 6 | This device's identifier |
| cfg_nap_wake | input | 8 | Nap wake time in serial ticks |
| cfg_pdn_wake | input | 8 | Power-down wake time in units of 256 serial ticks |
| cfg_nap_slow | input | 1 | Long post-exit entry lockout after a nap |
| cfg_pdn_slow | input | 1 | Long post-exit entry lockout after a power-down |
| sio_out | output | 1 | Serial line repeated to the next device |
| pstate | output | 5 | One-hot power state |
| arrive | output | 1 | One-cycle pulse on reaching attention or standby after an exit |
| row_blk | output | 1 | Row packets forbidden |
| col_blk | output | 1 | Column packets forbidden |
| proto_err | output | 1 | Sticky protocol error |

## Verification
Exit sequences are run for both states with random wake fields, relax and active-variant settings, in both broadcast and addressed modes. Comparing the measured exiting duration and the two blocking-flag counts against N×DIV separates the nap scaling from the power-down scaling and shows whether the active-variant capture is correct. Directed cases cover the rest: frames with a wrong identifier, frames sent inside the entry lockout, entry requests on either side of the 8- and 23-cycle post-exit windows, and frames arriving in the wrong state or carrying the wrong code. Each of these isolates one acceptance rule.

// File: rtl/lpx_pkg.sv
// Shared types for the low-power exit sequencer.
// Assumes: the power state is kept one-hot so a single bit can be decoded downstream.
package lpx_pkg;
    typedef enum logic [4:0] {
        ST_ATTN = 5'b00001,
        ST_STBY = 5'b00010,
        ST_NAP  = 5'b00100,
        ST_PDN  = 5'b01000,
        ST_EXIT = 5'b10000
    } pstate_e;

    typedef enum logic [1:0] {
        FR_SEEK0 = 2'd0,
        FR_SEEK1 = 2'd1,
        FR_CODE  = 2'd2,
        FR_ID    = 2'd3
    } frame_e;
endpackage

// File: rtl/lpx_tick_gen.sv
// Serial-rate enable generator.
// Produces a one-clock tick every DIV clocks, counted from reset release.
// Assumes: DIV >= 2.
module lpx_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_cnt;

    // Free-running divider that wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (div_cnt == DW'(DIV - 1))
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + DW'(1);
    end

    assign tick = (div_cnt == DW'(DIV - 1));
endmodule

// File: rtl/lpx_down_ctr.sv
// Loadable down counter that holds at zero.
// A load takes priority over a decrement.
// Assumes: the caller decodes the counter value it needs.
module lpx_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    // Load, or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (dec && cnt != '0)
            cnt <= cnt - W'(1);
    end
endmodule

// File: rtl/lpx_frame_rx.sv
// Serial exit-frame receiver and line repeater.
// Frame layout: 0, 1, code, then IDW identifier bits MSB first (not sent in broadcast mode).
// hit is combinational and valid in the tick cycle that samples the last bit,
// and only when the frame is broadcast or carries this device's identifier.
// Assumes: IDW >= 2; the line idles low between frames.
module lpx_frame_rx #(
    parameter int IDW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           scmd,
    input  logic           bcast,
    input  logic [IDW-1:0] dev_id,
    output logic           hit,
    output logic           code,
    output logic           sio_out
);
    import lpx_pkg::*;

    localparam int BW = $clog2(IDW);

    frame_e         stage;
    logic [BW-1:0]  bit_cnt;
    logic [IDW-2:0] id_sh;
    logic           code_q;
    logic           id_last;

    assign id_last = (stage == FR_ID) && (bit_cnt == BW'(IDW - 1));

    // Walk through the frame fields, one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage   <= FR_SEEK0;
            bit_cnt <= '0;
            id_sh   <= '0;
            code_q  <= 1'b0;
        end else if (tick) begin
            unique case (stage)
                FR_SEEK0: if (!scmd) stage <= FR_SEEK1;
                FR_SEEK1: if (scmd) stage <= FR_CODE;
                FR_CODE: begin
                    code_q  <= scmd;
                    bit_cnt <= '0;
                    stage   <= bcast ? FR_SEEK0 : FR_ID;
                end
                FR_ID: begin
                    id_sh   <= {id_sh[IDW-3:0], scmd};
                    bit_cnt <= bit_cnt + BW'(1);
                    if (id_last) stage <= FR_SEEK0;
                end
                default: stage <= FR_SEEK0;
            endcase
        end
    end

    // Repeat the sampled line to the next device.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sio_out <= 1'b0;
        else if (tick)
            sio_out <= scmd;
    end

    assign code = (stage == FR_CODE) ? scmd : code_q;
    assign hit  = tick && (((stage == FR_CODE) && bcast) ||
                           (id_last && ({id_sh, scmd} == dev_id)));
endmodule

// File: rtl/lpx_exit_seq.sv
// Low-power state sequencer for one memory device.
// Handles entry into nap or power-down, exit through serial frames, wake timing,
// the two lockout windows and the packet-blocking flags.
// Assumes: all configuration inputs are static while a sequence is in progress.
module lpx_exit_seq #(
    parameter int DIV        = 4,
    parameter int IDW        = 6,
    parameter int XW         = 8,
    parameter int LOCK_FAST  = 5,
    parameter int POST_SHORT = 8,
    parameter int POST_LONG  = 23
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ent_req,
    input  logic           ent_pdn,
    input  logic           ent_relax,
    input  logic           ent_avar,
    input  logic           scmd,
    input  logic           cfg_bcast,
    input  logic [IDW-1:0] cfg_dev_id,
    input  logic [XW-1:0]  cfg_nap_wake,
    input  logic [XW-1:0]  cfg_pdn_wake,
    input  logic           cfg_nap_slow,
    input  logic           cfg_pdn_slow,
    output logic           sio_out,
    output logic [4:0]     pstate,
    output logic           arrive,
    output logic           row_blk,
    output logic           col_blk,
    output logic           proto_err
);
    import lpx_pkg::*;

    localparam int CW  = XW + 9;
    localparam int LFW = $clog2(LOCK_FAST + 1);
    localparam int PW  = $clog2(POST_LONG + 1);

    logic          tick;
    logic          hit;
    logic          fr_code;
    pstate_e       state, state_n;
    logic          relax_q, avar_q, kind_q;
    logic [CW-1:0] nap_n, pdn_n, wake_cnt, lock_cnt;
    logic [LFW-1:0] fast_cnt;
    logic [PW-1:0] post_cnt;
    logic          ld_wake, ld_lock, ld_post, err_set, arr_n;
    logic          lock_act, ent_ok, is_low;

    lpx_tick_gen #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    lpx_frame_rx #(.IDW(IDW)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scmd(scmd),
        .bcast(cfg_bcast), .dev_id(cfg_dev_id),
        .hit(hit), .code(fr_code), .sio_out(sio_out)
    );

    // Wake lengths in serial ticks; a zero field counts as one tick.
    assign nap_n = (cfg_nap_wake == '0) ? CW'(1) : CW'(cfg_nap_wake);
    assign pdn_n = (cfg_pdn_wake == '0) ? CW'(1) : {1'b0, cfg_pdn_wake, 8'h00};

    lpx_down_ctr #(.W(CW)) u_wake (
        .clk(clk), .rst_n(rst_n), .load(ld_wake),
        .val(kind_q ? pdn_n : nap_n),
        .dec(tick && state == ST_EXIT), .cnt(wake_cnt)
    );

    lpx_down_ctr #(.W(LFW)) u_lock_fast (
        .clk(clk), .rst_n(rst_n), .load(ld_lock),
        .val(LFW'(LOCK_FAST)), .dec(1'b1), .cnt(fast_cnt)
    );

    lpx_down_ctr #(.W(CW)) u_lock_tick (
        .clk(clk), .rst_n(rst_n), .load(ld_lock),
        .val((ent_pdn ? pdn_n : nap_n) + CW'(2)),
        .dec(tick && fast_cnt == '0), .cnt(lock_cnt)
    );

    lpx_down_ctr #(.W(PW)) u_post (
        .clk(clk), .rst_n(rst_n), .load(ld_post),
        .val((kind_q ? cfg_pdn_slow : cfg_nap_slow) ? PW'(POST_LONG) : PW'(POST_SHORT)),
        .dec(1'b1), .cnt(post_cnt)
    );

    assign lock_act = (fast_cnt != '0) || (lock_cnt != '0);
    assign is_low   = (state == ST_NAP) || (state == ST_PDN);
    assign ent_ok   = ent_req && (post_cnt == '0) &&
                      ((state == ST_ATTN) || (state == ST_STBY));

    // Next power state and the load strobes for the counters.
    always_comb begin
        state_n = state;
        ld_wake = 1'b0;
        ld_lock = 1'b0;
        ld_post = 1'b0;
        err_set = 1'b0;
        arr_n   = 1'b0;
        unique case (state)
            ST_ATTN, ST_STBY: begin
                if (ent_ok) begin
                    state_n = ent_pdn ? ST_PDN : ST_NAP;
                    ld_lock = 1'b1;
                end
                if (hit) err_set = 1'b1;
            end
            ST_NAP, ST_PDN: begin
                if (hit && !lock_act) begin
                    if (fr_code == (state == ST_PDN)) begin
                        state_n = ST_EXIT;
                        ld_wake = 1'b1;
                    end else begin
                        err_set = 1'b1;
                    end
                end
            end
            ST_EXIT: begin
                if (hit) err_set = 1'b1;
                if (tick && wake_cnt == CW'(1)) begin
                    state_n = relax_q ? ST_STBY : ST_ATTN;
                    arr_n   = 1'b1;
                    ld_post = 1'b1;
                end
            end
            default: state_n = ST_STBY;
        endcase
    end

    // State register, arrival pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_STBY;
            arrive    <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            state     <= state_n;
            arrive    <= arr_n;
            proto_err <= proto_err | err_set;
        end
    end

    // Capture the entry attributes used by the later exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relax_q <= 1'b0;
            avar_q  <= 1'b0;
            kind_q  <= 1'b0;
        end else if (ld_lock) begin
            relax_q <= ent_relax;
            avar_q  <= ent_avar;
            kind_q  <= ent_pdn;
        end
    end

    assign pstate  = state;
    assign row_blk = (state == ST_EXIT);
    assign col_blk = row_blk && avar_q;
endmodule

// File: rtl/lpx_exit_seq_chk.sv
// Property checker for lpx_exit_seq, attached to it by bind.
// Assumes: the state encoding of lpx_pkg (bit 0 attention ... bit 4 exiting).
module lpx_exit_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       scmd,
    input logic [4:0] pstate,
    input logic       arrive,
    input logic       row_blk,
    input logic       col_blk,
    input logic       proto_err,
    input logic       sio_out
);
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pstate) == 1);

    p_entry_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pstate[2]) || $rose(pstate[3])) |-> $past(pstate[0] || pstate[1]));

    p_exit_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pstate[4]) |-> $past(pstate[2] || pstate[3]));

    p_arrive_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arrive |-> ((pstate[0] || pstate[1]) && $past(pstate[4])));

    p_arrive_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arrive |=> !arrive);

    p_col_in_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col_blk |-> row_blk);

    p_nap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pstate[2] |=> (pstate[2] || pstate[4]));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    p_repeat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (sio_out == $past(scmd)));
endmodule

bind lpx_exit_seq lpx_exit_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scmd(scmd), .pstate(pstate),
    .arrive(arrive), .row_blk(row_blk), .col_blk(col_blk),
    .proto_err(proto_err), .sio_out(sio_out)
);

// File: tb/test_lpx_exit_seq.sv
module test_lpx_exit_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam logic [4:0] S_ATTN = 5'b00001, S_STBY = 5'b00010,
                           S_NAP = 5'b00100, S_PDN = 5'b01000, S_EXIT = 5'b10000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       rst_n = 1'b0;
    logic       ent_req = 0, ent_pdn = 0, ent_relax = 0, ent_avar = 0, scmd = 0;
    logic       cfg_bcast = 0, cfg_nap_slow = 0, cfg_pdn_slow = 0;
    logic [5:0] cfg_dev_id = 6'h2B;
    logic [7:0] cfg_nap_wake = 8'd3, cfg_pdn_wake = 8'd0;
    logic       sio_out, arrive, row_blk, col_blk, proto_err;
    logic [4:0] pstate;

    lpx_exit_seq #(.DIV(DIV)) i_lpx_exit_seq (
        .clk(clk), .rst_n(rst_n), .ent_req(ent_req), .ent_pdn(ent_pdn),
        .ent_relax(ent_relax), .ent_avar(ent_avar), .scmd(scmd),
        .cfg_bcast(cfg_bcast), .cfg_dev_id(cfg_dev_id),
        .cfg_nap_wake(cfg_nap_wake), .cfg_pdn_wake(cfg_pdn_wake),
        .cfg_nap_slow(cfg_nap_slow), .cfg_pdn_slow(cfg_pdn_slow),
        .sio_out(sio_out), .pstate(pstate), .arrive(arrive),
        .row_blk(row_blk), .col_blk(col_blk), .proto_err(proto_err)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    bit got_arrive;
    int unsigned ecnt;
    int mcnt = 0, mrow = 0, mcol = 0, lat_len = 0, lat_row = 0, lat_col = 0;

    // Index of the next clock edge since reset release.
    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    // Measure each exiting period and its blocking flags.
    always @(negedge clk) begin
        if (pstate == S_EXIT) begin
            mcnt = mcnt + 1;
            if (row_blk) mrow = mrow + 1;
            if (col_blk) mcol = mcol + 1;
        end
        if (arrive) begin
            lat_len = mcnt; lat_row = mrow; lat_col = mcol;
            mcnt = 0; mrow = 0; mcol = 0;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wake_n(input bit kind, input int napx, input int pdnx);
        if (kind) return (pdnx == 0) ? 1 : 256 * pdnx;
        return (napx == 0) ? 1 : napx;
    endfunction

    function automatic int lock_wait(input int n);
        return 5 + (2 + n) * DIV + 2 * DIV;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; ent_req = 0; scmd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic serial_bit(input logic b);
        forever begin
            @(negedge clk);
            if (ecnt % DIV == DIV - 1) break;
        end
        scmd = b;
        @(posedge clk);
        #1;
        check_eq("R11", "serial repeat", int'(sio_out), int'(b));
    endtask

    task automatic send_frame(input logic code, input bit use_id, input logic [5:0] id);
        serial_bit(1'b0);
        serial_bit(1'b1);
        serial_bit(code);
        if (use_id)
            for (int i = 5; i >= 0; i--) serial_bit(id[i]);
        @(negedge clk);
        scmd = 1'b0;
    endtask

    task automatic enter(input bit kind, input bit relax, input bit avar);
        @(negedge clk);
        ent_pdn = kind; ent_relax = relax; ent_avar = avar; ent_req = 1;
        @(negedge clk);
        ent_req = 0;
    endtask

    task automatic wait_arrive(input int limit);
        got_arrive = 0;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (arrive) begin
                got_arrive = 1;
                break;
            end
        end
        check_eq("R6", "arrival seen", int'(got_arrive), 1);
    endtask

    // Full entry/exit sequence with latency and flag checks.
    task automatic run_exit(input bit kind, input bit relax, input bit avar, input bit bc,
                            input bit badid, input int napx, input int pdnx);
        int n;
        n = wake_n(kind, napx, pdnx);
        cfg_bcast = bc; cfg_nap_wake = 8'(napx); cfg_pdn_wake = 8'(pdnx);
        enter(kind, relax, avar);
        check_eq("R2", "entered state", int'(pstate), int'(kind ? S_PDN : S_NAP));
        repeat (lock_wait(n)) @(negedge clk);
        if (badid && !bc) begin
            send_frame(kind, 1, cfg_dev_id ^ 6'h04);
            repeat (3 * DIV) @(negedge clk);
            check_eq("R4", "state after foreign id", int'(pstate), int'(kind ? S_PDN : S_NAP));
            check_eq("R4", "no error on foreign id", int'(proto_err), 0);
        end
        send_frame(kind, !bc, cfg_dev_id);
        check_eq("R3", "exiting after frame", int'(pstate), int'(S_EXIT));
        wait_arrive(n * DIV + 4 * DIV);
        check_eq("R6", "return state", int'(pstate), int'(relax ? S_STBY : S_ATTN));
        @(negedge clk);
        check_eq("R6", "arrive one cycle", int'(arrive), 0);
        check_eq("R5", "exit length", lat_len, n * DIV + 0 * 0 + 0);
        check_eq("R7", "row block cycles", lat_row, n * DIV);
        check_eq("R7", "col block cycles", lat_col, avar ? n * DIV : 0);
        repeat (24) @(negedge clk);
    endtask

    // Post-exit entry window: ignored at cycle L, accepted at L+1.
    task automatic post_lock(input bit kind, input bit slow);
        int l;
        l = slow ? 23 : 8;
        cfg_bcast = 1; cfg_nap_wake = 8'd2; cfg_pdn_wake = 8'd0;
        cfg_nap_slow = kind ? !slow : slow;
        cfg_pdn_slow = kind ? slow : !slow;
        enter(kind, 0, 0);
        repeat (lock_wait(wake_n(kind, 2, 0))) @(negedge clk);
        send_frame(kind, 0, 6'h00);
        wait_arrive(10 * DIV);
        repeat (l - 1) @(negedge clk);
        ent_pdn = 0; ent_relax = 1; ent_avar = 0; ent_req = 1;
        @(negedge clk);
        check_eq("R9", "entry ignored in window", int'(pstate), int'(S_ATTN));
        @(negedge clk);
        ent_req = 0;
        check_eq("R9", "entry accepted after window", int'(pstate), int'(S_NAP));
        repeat (lock_wait(2)) @(negedge clk);
        send_frame(1'b0, 0, 6'h00);
        wait_arrive(10 * DIV);
        repeat (24) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1));
        do_reset();
        @(negedge clk);
        check_eq("R1", "reset state", int'(pstate), int'(S_STBY));
        check_eq("R1", "reset flags", int'({arrive, row_blk, col_blk, proto_err}), 0);

        // Directed: boundaries of the wake fields and both addressing modes.
        run_exit(0, 1, 1, 0, 1, 3, 0);
        run_exit(0, 0, 0, 1, 0, 0, 0);
        run_exit(1, 1, 0, 0, 1, 0, 0);
        run_exit(1, 0, 1, 1, 0, 0, 1);

        // Random sequences.
        for (int it = 0; it < 12; it++) begin
            bit k, rl, av, bc, bi;
            k = 1'($urandom % 2); rl = 1'($urandom % 2); av = 1'($urandom % 2);
            bc = 1'($urandom % 2); bi = 1'($urandom % 2);
            run_exit(k, rl, av, bc, bi, 1 + int'($urandom % 6), int'($urandom % 2));
        end

        // Entry lockout: early frame discarded, entry in nap ignored.
        cfg_bcast = 1; cfg_nap_wake = 8'd5;
        enter(0, 1, 0);
        @(negedge clk);
        ent_pdn = 1; ent_req = 1;
        @(negedge clk);
        ent_req = 0;
        @(negedge clk);
        check_eq("R2", "entry ignored in nap", int'(pstate), int'(S_NAP));
        send_frame(1'b0, 0, 6'h00);
        @(negedge clk);
        check_eq("R8", "early frame discarded", int'(pstate), int'(S_NAP));
        check_eq("R8", "no error for early frame", int'(proto_err), 0);
        repeat (lock_wait(5)) @(negedge clk);
        send_frame(1'b0, 0, 6'h00);
        wait_arrive(10 * DIV);
        check_eq("R8", "later frame accepted", int'(pstate), int'(S_STBY));
        repeat (24) @(negedge clk);

        post_lock(0, 0);
        post_lock(1, 1);
        post_lock(0, 1);

        // Protocol errors.
        cfg_bcast = 1;
        send_frame(1'b0, 0, 6'h00);
        @(negedge clk);
        check_eq("R10", "error on frame in standby", int'(proto_err), 1);
        check_eq("R10", "standby kept", int'(pstate), int'(S_STBY));
        do_reset();
        @(negedge clk);
        check_eq("R1", "error cleared by reset", int'(proto_err), 0);
        cfg_pdn_wake = 8'd0;
        enter(1, 1, 0);
        repeat (lock_wait(1)) @(negedge clk);
        send_frame(1'b0, 0, 6'h00);
        @(negedge clk);
        check_eq("R10", "error on code mismatch", int'(proto_err), 1);
        check_eq("R10", "power-down kept", int'(pstate), int'(S_PDN));
        send_frame(1'b1, 0, 6'h00);
        wait_arrive(10 * DIV);
        check_eq("R10", "error stays set", int'(proto_err), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule